// File: doc/BRIEF.md
# Burst Transmit Clock Selector

This block sits in front of a QPSK modulator data path and turns a raw transmit clock pin, a serial data pin and a burst window pin into symbol-rate data that the modulator can consume. A mode input chooses where the 384 kHz symbol-rate clock comes from. In pass-through mode the pin already carries a continuous 384 kHz clock that is in step with the data. In divided mode the pin carries a 3.84 MHz clock, which is divided by ten inside the block. The selected 384 kHz clock is also driven out for monitoring.

Every pin is brought into a faster system clock domain through a two-flop synchronizer. Clock edges are found by comparing successive samples, so no pin is used as a clock. Serial bits are captured on the rising edge of the selected clock and joined into 2-bit symbols. Capture only happens while the burst window is high and modulation is enabled. A registered burst indicator follows the window so that downstream logic can see where the output burst sits.

Top module: `burst_txclk_sel`

## Requirements
- R1: While rst_ni is low, clk_mon_o, sym_o, sym_valid_o and burst_o are all 0.
- R2: With fast_mode_i = 0, clk_mon_o repeats txclk_i, delayed by two system clock cycles.
- R3: With fast_mode_i = 1, clk_mon_o has a period of ten txclk_i rising edges. It goes high on the 1st rising edge counted after the mode is entered and stays high through the 5th edge. It is low from the 6th through the 10th edge, and the pattern then repeats. Any change of fast_mode_i restarts this count.
- R4: With fast_mode_i = 1, the divider keeps its state while txclk_i stops toggling. When the clock resumes, the count carries on from where it stopped.
- R5: With fast_mode_i = 0, txd_i is captured on each rising edge of txclk_i.
- R6: With fast_mode_i = 1, txd_i is captured only on the rising edges of the divided clock, which are fast edges 1, 11, 21 and so on.
- R7: Captured bits are paired into symbols. The first bit captured after the window opens goes to sym_o[1] and the second to sym_o[0]. sym_valid_o is a one-cycle pulse that marks each completed pair.
- R8: While win_i is 0, nothing is captured. A half-filled pair is discarded when the window closes.
- R9: While mod_off_i is 1, no symbols are produced and any half-filled pair is discarded. A value of 0 enables modulation.
- R10: burst_o follows win_i three system cycles later and does not depend on mod_off_i.
- R11: sym_valid_o rises three system cycles after the txclk_i rising edge that captures the second bit of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txclk_i | input | 1 | Transmit clock pin (384 kHz or 3.84 MHz) |
| txd_i | input | 1 | Serial transmit data |
| win_i | input | 1 | Burst window; data is accepted only while high |
| fast_mode_i | input | 1 | 0: pass-through clock, 1: divide-by-ten clock |
| mod_off_i | input | 1 | 1 disables modulation |
| clk_mon_o | output | 1 | Selected 384 kHz clock for monitoring |
| sym_o | output | 2 | Last completed symbol, first bit in bit 1 |
| sym_valid_o | output | 1 | One-cycle strobe for sym_o |
| burst_o | output | 1 | Burst position indicator |

## Verification
Each pin passes through two synchronizer flops before any logic sees it. In pass-through mode the monitor clock therefore lags txclk_i by two cycles. The divided clock, the symbol strobe and the burst indicator each add one more register and lag by three cycles. All stimulus is driven on falling clock edges. The latency checks sample on the falling edges one, two and three cycles after the stimulus and expect the change on exactly the predicted one. The divided-clock checks wait three cycles after every fast edge before reading clk_mon_o. Symbol contents and counts are recorded by a monitor on falling edges and compared after each scenario has settled.

// File: rtl/burst_txclk_pkg.sv
package burst_txclk_pkg;
  localparam int unsigned DIV_RATIO   = 10;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic txclk;
    logic txd;
    logic win;
    logic fast;
    logic mod_off;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);
endpackage

// File: rtl/btc_sync.sv
module btc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[g] <= '0;
      else if (g == 0) st[g] <= d_i;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/btc_div.sv
module btc_div #(
  parameter int unsigned DIV = 10,
  localparam int unsigned CW = $clog2(DIV),
  localparam int unsigned HALF = DIV / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_mode_i,
  input  logic          mode_chg_i,
  input  logic          edge_i,
  output logic          div_clk_o,
  output logic          div_rise_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          div_q;
  logic          run;

  assign run = fast_mode_i && !mode_chg_i;

  always_comb begin
    cnt_nxt = (cnt_q == CW'(DIV-1)) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt != '0) && (cnt_nxt <= CW'(HALF));
    end
  end

  // divided clock rises when count steps onto 1
  assign div_rise_o = run && edge_i && (cnt_nxt == CW'(1));
  assign div_clk_o  = div_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/btc_pack.sv
module btc_pack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       bit_i,
  input  logic       win_i,
  input  logic       mod_off_i,
  output logic [1:0] sym_o,
  output logic       valid_o
);
  logic half_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      sym_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!win_i || mod_off_i) begin
        half_q <= 1'b0;
      end else if (stb_i) begin
        if (!half_q) begin
          first_q <= bit_i;
          half_q  <= 1'b1;
        end else begin
          sym_o   <= {first_q, bit_i};
          valid_o <= 1'b1;
          half_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/burst_txclk_sel.sv
module burst_txclk_sel
  import burst_txclk_pkg::*;
#(
  parameter int unsigned DIV    = DIV_RATIO,
  parameter int unsigned STAGES = SYNC_STAGES,
  localparam int unsigned CW    = $clog2(DIV)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txclk_i,
  input  logic       txd_i,
  input  logic       win_i,
  input  logic       fast_mode_i,
  input  logic       mod_off_i,
  output logic       clk_mon_o,
  output logic [1:0] sym_o,
  output logic       sym_valid_o,
  output logic       burst_o
);
  pins_t         raw, s;
  logic          txclk_q, mode_q, burst_q;
  logic          txclk_rise, mode_chg;
  logic          div_clk, div_rise, cap_stb;
  logic [CW-1:0] div_cnt;

  always_comb begin
    raw.txclk   = txclk_i;
    raw.txd     = txd_i;
    raw.win     = win_i;
    raw.fast    = fast_mode_i;
    raw.mod_off = mod_off_i;
  end

  btc_sync #(.W(PINS_W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txclk_q <= 1'b0;
      mode_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      txclk_q <= s.txclk;
      mode_q  <= s.fast;
      burst_q <= s.win;
    end
  end

  assign txclk_rise = s.txclk & ~txclk_q;
  assign mode_chg   = s.fast ^ mode_q;

  btc_div #(.DIV(DIV)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_mode_i(s.fast),
    .mode_chg_i (mode_chg),
    .edge_i     (txclk_rise),
    .div_clk_o  (div_clk),
    .div_rise_o (div_rise),
    .cnt_o      (div_cnt)
  );

  assign cap_stb = s.fast ? div_rise : (txclk_rise & ~mode_chg);

  btc_pack u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (cap_stb),
    .bit_i    (s.txd),
    .win_i    (s.win),
    .mod_off_i(s.mod_off),
    .sym_o    (sym_o),
    .valid_o  (sym_valid_o)
  );

  assign clk_mon_o = s.fast ? div_clk : s.txclk;
  assign burst_o   = burst_q;
endmodule

// File: rtl/burst_txclk_sel_chk.sv
module burst_txclk_sel_chk #(
  parameter int unsigned DIV = 10,
  localparam int unsigned CW = $clog2(DIV)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          txclk_rise,
  input logic          mode_chg,
  input logic [CW-1:0] div_cnt,
  input logic          mod_off_s,
  input logic          sym_valid_o,
  input logic          burst_o
);
  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt < CW'(DIV));

  assert_cnt_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (div_cnt == '0));

  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txclk_rise && !mode_chg) |=> $stable(div_cnt));

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o);

  assert_valid_in_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> burst_o);

  assert_valid_mod_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sym_valid_o) |-> $past(!mod_off_s));
endmodule

bind burst_txclk_sel burst_txclk_sel_chk #(.DIV(DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .txclk_rise (txclk_rise),
  .mode_chg   (mode_chg),
  .div_cnt    (div_cnt),
  .mod_off_s  (s.mod_off),
  .sym_valid_o(sym_valid_o),
  .burst_o    (burst_o)
);

// File: tb/burst_txclk_sel_tb.sv
module burst_txclk_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txclk = 1'b0, txd = 1'b0, win = 1'b0, fast = 1'b0, mod_off = 1'b0;
  logic       clk_mon, sym_valid, burst;
  logic [1:0] sym;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  int         n_sym = 0;
  logic [1:0] syms [64];

  always #10 clk = ~clk;

  burst_txclk_sel u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .txclk_i    (txclk),
    .txd_i      (txd),
    .win_i      (win),
    .fast_mode_i(fast),
    .mod_off_i  (mod_off),
    .clk_mon_o  (clk_mon),
    .sym_o      (sym),
    .sym_valid_o(sym_valid),
    .burst_o    (burst)
  );

  always @(negedge clk) begin
    if (rst_n && sym_valid) begin
      if (n_sym < 64) syms[n_sym] <= sym;
      n_sym <= n_sym + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send0(input logic b);
    txd = b; txclk = 1'b0; cyc(4);
    txclk = 1'b1; cyc(4);
    txclk = 1'b0;
  endtask

  // one fast-clock pulse; returns clk_mon three cycles after the rise
  task automatic fpulse(output logic mon);
    txclk = 1'b1; cyc(3);
    mon = clk_mon;
    txclk = 1'b0; cyc(3);
  endtask

  function automatic logic div_exp(input int k);
    return (k % 10 >= 1) && (k % 10 <= 5);
  endfunction

  task automatic t_reset;
    cyc(3);
    chk({clk_mon, sym, sym_valid, burst} == 5'b0, "R1 outputs in reset", int'({clk_mon, sym, sym_valid, burst}), 0);
    rst_n = 1'b1; cyc(3);
    chk({sym_valid, burst} == 2'b0, "R1 idle after reset", int'({sym_valid, burst}), 0);
  endtask

  task automatic t_mode0_data;
    int base;
    logic [1:0] exp_s [4];
    exp_s = '{2'd2, 2'd1, 2'd3, 2'd0};
    fast = 1'b0; mod_off = 1'b0; win = 1'b1; cyc(6);
    base = n_sym;
    send0(1); send0(0); send0(0); send0(1);
    send0(1); send0(1); send0(0); send0(0);
    cyc(4);
    chk(n_sym - base == 4, "R5 symbol count", n_sym - base, 4);
    for (int i = 0; i < 4; i++)
      chk(syms[base+i] == exp_s[i], "R7 symbol order", int'(syms[base+i]), int'(exp_s[i]));
    win = 1'b0; cyc(6);
  endtask

  task automatic t_latency;
    fast = 1'b0; win = 1'b1; cyc(6);
    send0(1);
    txd = 1'b0; txclk = 1'b0; cyc(4);
    txclk = 1'b1;
    cyc(1);
    chk(clk_mon == 1'b0, "R2 mon at +1", int'(clk_mon), 0);
    chk(sym_valid == 1'b0, "R11 valid at +1", int'(sym_valid), 0);
    cyc(1);
    chk(clk_mon == 1'b1, "R2 mon at +2", int'(clk_mon), 1);
    chk(sym_valid == 1'b0, "R11 valid at +2", int'(sym_valid), 0);
    cyc(1);
    chk(sym_valid == 1'b1, "R11 valid at +3", int'(sym_valid), 1);
    chk(sym == 2'd2, "R11 symbol at +3", int'(sym), 2);
    cyc(1);
    chk(sym_valid == 1'b0, "R7 single pulse", int'(sym_valid), 0);
    txclk = 1'b0; cyc(4);
    win = 1'b0; cyc(6);
  endtask

  task automatic t_window;
    int base;
    fast = 1'b0; win = 1'b0; cyc(6);
    base = n_sym;
    send0(1); send0(0); send0(1); send0(1);
    cyc(4);
    chk(n_sym == base, "R8 closed window", n_sym - base, 0);
    win = 1'b1; cyc(6);
    send0(1);
    win = 1'b0; cyc(6);
    win = 1'b1; cyc(6);
    send0(0); send0(1);
    cyc(4);
    chk(n_sym - base == 1, "R8 pair count", n_sym - base, 1);
    chk(syms[base] == 2'd1, "R8 half pair dropped", int'(syms[base]), 1);
    win = 1'b0; cyc(6);
  endtask

  task automatic t_burst;
    win = 1'b0; mod_off = 1'b0; cyc(6);
    win = 1'b1;
    cyc(2);
    chk(burst == 1'b0, "R10 burst at +2", int'(burst), 0);
    cyc(1);
    chk(burst == 1'b1, "R10 burst at +3", int'(burst), 1);
    mod_off = 1'b1; cyc(6);
    chk(burst == 1'b1, "R10 burst with mod off", int'(burst), 1);
    mod_off = 1'b0; win = 1'b0; cyc(6);
    chk(burst == 1'b0, "R10 burst after close", int'(burst), 0);
  endtask

  task automatic t_modoff;
    int base;
    fast = 1'b0; win = 1'b1; mod_off = 1'b1; cyc(6);
    base = n_sym;
    send0(1); send0(1); send0(1);
    cyc(4);
    chk(n_sym == base, "R9 no symbols when off", n_sym - base, 0);
    mod_off = 1'b0; cyc(6);
    send0(0); send0(1);
    cyc(4);
    chk(n_sym - base == 1, "R9 count after enable", n_sym - base, 1);
    chk(syms[base] == 2'd1, "R9 fresh pair", int'(syms[base]), 1);
    win = 1'b0; cyc(6);
  endtask

  task automatic t_divider;
    logic mon;
    int bad;
    win = 1'b0; txclk = 1'b0; fast = 1'b1; cyc(6);
    bad = 0;
    for (int k = 1; k <= 3; k++) begin
      fpulse(mon);
      if (mon != div_exp(k)) bad++;
    end
    chk(bad == 0, "R3 first edges", bad, 0);
    cyc(30);
    chk(clk_mon == 1'b1, "R4 hold while idle", int'(clk_mon), 1);
    bad = 0;
    for (int k = 4; k <= 7; k++) begin
      fpulse(mon);
      if (mon != div_exp(k)) bad++;
    end
    chk(bad == 0, "R4 resume count", bad, 0);
    chk(clk_mon == 1'b0, "R3 low phase at 7", int'(clk_mon), 0);
    fast = 1'b0; cyc(6);
    chk(clk_mon == 1'b0, "R2 mon follows idle pin", int'(clk_mon), 0);
    fast = 1'b1; cyc(6);
    bad = 0;
    for (int k = 1; k <= 12; k++) begin
      fpulse(mon);
      if (mon != div_exp(k)) begin
        bad++;
        $display("FAIL R3 edge %0d: actual %0d expected %0d", k, mon, div_exp(k));
      end
    end
    chk(bad == 0, "R3 restart and full period", bad, 0);
    fast = 1'b0; cyc(6);
  endtask

  task automatic t_mode1_data;
    int base;
    logic mon;
    logic b [4];
    b = '{1'b1, 1'b1, 1'b0, 1'b1};
    win = 1'b0; txclk = 1'b0; fast = 1'b0; cyc(6);
    fast = 1'b1; cyc(6);
    win = 1'b1; cyc(6);
    base = n_sym;
    for (int k = 1; k <= 31; k++) begin
      if (k % 10 == 1) begin
        txd = b[k/10]; cyc(2);
      end else begin
        txd = ~txd;
      end
      fpulse(mon);
    end
    cyc(4);
    chk(n_sym - base == 2, "R6 divided capture count", n_sym - base, 2);
    chk(syms[base] == 2'd3, "R6 first symbol", int'(syms[base]), 3);
    chk(syms[base+1] == 2'd1, "R6 second symbol", int'(syms[base+1]), 1);
    win = 1'b0; fast = 1'b0; cyc(6);
  endtask

  initial begin
    t_reset();
    t_mode0_data();
    t_latency();
    t_window();
    t_burst();
    t_modoff();
    t_divider();
    t_mode1_data();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule